// File: doc/BRIEF.md
# Three-Level Escalating Watchdog Supervisor

This block supervises a processor with a chain of three timers that escalate one after another. Software programs a reload value for each level and a tick prescaler through a small write-only register port. It then services the watchdog by writing to a kick address. If software stops kicking, level 1 runs out first and raises a maskable interrupt (health WARNING). Level 2 then runs and, on expiry, fires a non-maskable abort pulse (health COPING). Level 3 runs last and, on expiry, latches a serious alarm and, if the board allows it, a power-on-reset request (health FAILED).

The health state machine has four states: NORMAL, WARNING, COPING and FAILED. It has five transitions. EXPIRE1 goes from NORMAL to WARNING, EXPIRE2 from WARNING to COPING, and EXPIRE3 from COPING to FAILED. KICK returns WARNING or COPING to NORMAL. STRAP_OFF forces any state back to NORMAL when the enable strap is low. Only one level counts at a time: level 1 in NORMAL, level 2 in WARNING, level 3 in COPING. Any level that is not counting is held at its reload value. The expiry of a higher level therefore reloads every level below it. A two-bit LED code follows the health state.

All three levels count a shared tick. A programmable clock divider produces this tick; its reset value gives 1 ms at 125 MHz.

Top module: `wdt3_supervisor`

## Requirements
- R1: Health is encoded 00 NORMAL, 01 WARNING, 10 COPING, 11 FAILED. After reset, health is NORMAL and every output is 0. On level 1 expiry (EXPIRE1), health becomes WARNING and `irq_o` goes high. `irq_o` stays high in every state other than NORMAL.
- R2: Level 2 counts only in WARNING. On its expiry (EXPIRE2), health becomes COPING and `nmi_o` is high for exactly one cycle.
- R3: Level 3 counts only in COPING. On its expiry (EXPIRE3), health becomes FAILED and `alarm_o` goes high. FAILED holds and kicks are ignored until reset or until the enable strap drops.
- R4: `por_req_o` goes high on EXPIRE3 only if `por_en_strap` is 1 at that edge. Once set, it stays high in FAILED.
- R5: The tick comes every P clocks, where P is the prescaler value; P = 0 acts as 1. A kick or a prescaler write restarts the tick phase. Level n expires on the R_n-th tick of its own state, where R_n is its reload value (0 acts as 1). A kick reloads all levels, and a level that is not counting holds its reload value. With a kick landing at edge K, EXPIRE1 lands at edge K + P·R1.
- R6: `led_o` is 00 (off) in NORMAL and WARNING, 01 (amber) in COPING and 10 (red) in FAILED.
- R7: While `en_strap` is 0, health is forced to NORMAL one edge later, every output is 0, and kicks do nothing.
- R8: A kick (write to address 4) in WARNING or COPING returns health to NORMAL and clears `irq_o` at the same edge.
- R9: The register addresses are: 0, 1 and 2 hold the level 1, 2 and 3 reload values (bits 15:0); 3 holds the prescaler (bits 16:0); 4 is the kick. Writes to addresses 0 to 3 are accepted whatever the strap settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| en_strap | input | 1 | Board enable strap; 0 makes the block inert |
| por_en_strap | input | 1 | Allows the reset request on level 3 expiry |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (R9) |
| wr_data | input | 17 | Write data |
| health_o | output | 2 | Health state code (R1) |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | One-cycle non-maskable abort pulse |
| alarm_o | output | 1 | Serious-alarm output |
| por_req_o | output | 1 | Power-on-reset request |
| led_o | output | 2 | Alarm LED colour code (R6) |

## Verification
Count the edges from the one at which a kick lands (edge K). EXPIRE1 and its outputs are due at edge K + P·R1. EXPIRE2 is due P·R2 edges after that, and EXPIRE3 P·R3 edges after EXPIRE2. Each check also looks one edge earlier, where nothing may have changed yet. A kick, or the strap dropping, takes effect at the very next edge. The driver records the edge at which each write lands and queues the expected output word for the exact edge it is due. The monitor compares that word between edges, at the falling clock, so each check looks at one known cycle.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;

    localparam int unsigned NUM_LEVELS = 3;
    localparam int unsigned ADDR_W     = 3;

    // Register map: reload registers sit at addresses 0..NUM_LEVELS-1
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_KICK  = 3'd4;

    typedef enum logic [1:0] {
        HS_NORMAL  = 2'b00,
        HS_WARNING = 2'b01,
        HS_COPING  = 2'b10,
        HS_FAILED  = 2'b11
    } health_e;

    typedef enum logic [1:0] {
        LED_OFF   = 2'b00,
        LED_AMBER = 2'b01,
        LED_RED   = 2'b10
    } led_e;

endpackage

// File: rtl/wdt3_prescaler.sv
module wdt3_prescaler #(
    parameter int unsigned PRE_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] divisor,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    // A divisor of zero behaves like one: a tick every clock
    assign limit = (divisor == '0) ? '0 : divisor - PRE_W'(1);
    assign tick  = run && !restart && (phase_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart) begin
            phase_q <= '0;
        end else if (phase_q >= limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/wdt3_level.sv
module wdt3_level #(
    parameter int unsigned          CNT_W   = 16,
    parameter logic [CNT_W-1:0]     RST_VAL = 16'd1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload,
    input  logic             active,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] remain_q;

    // Expiry on the tick that would take the count to zero; 0 acts as 1
    assign expire = active && tick && !reload && (remain_q <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= RST_VAL;
        end else if (reload) begin
            remain_q <= reload_val;
        end else if (active && tick && (remain_q != '0)) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt3_health_fsm.sv
module wdt3_health_fsm
    import wdt3_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  kick,
    input  logic                  por_en,
    input  logic [NUM_LEVELS-1:0] expire,
    output health_e               state_o,
    output logic [NUM_LEVELS-1:0] active_o,
    output logic                  irq_o,
    output logic                  nmi_o,
    output logic                  alarm_o,
    output logic                  por_o,
    output led_e                  led_o
);
    health_e state_q;
    health_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: EXPIRE1/2/3, KICK, STRAP_OFF
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = HS_NORMAL;
        end else begin
            unique case (state_q)
                HS_NORMAL: begin
                    if (expire[0]) state_d = HS_WARNING;
                end
                HS_WARNING: begin
                    if (kick)           state_d = HS_NORMAL;
                    else if (expire[1]) state_d = HS_COPING;
                end
                HS_COPING: begin
                    if (kick)           state_d = HS_NORMAL;
                    else if (expire[2]) state_d = HS_FAILED;
                end
                HS_FAILED: begin
                    state_d = HS_FAILED;
                end
            endcase
        end
    end

    // Only the level that guards the current state counts
    always_comb begin
        active_o = '0;
        if (en) begin
            active_o[0] = (state_q == HS_NORMAL);
            active_o[1] = (state_q == HS_WARNING);
            active_o[2] = (state_q == HS_COPING);
        end
    end

    // Outputs, registered from the next state so they align with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o   <= 1'b0;
            nmi_o   <= 1'b0;
            alarm_o <= 1'b0;
            por_o   <= 1'b0;
            led_o   <= LED_OFF;
        end else begin
            irq_o   <= (state_d != HS_NORMAL);
            nmi_o   <= (state_q == HS_WARNING) && (state_d == HS_COPING);
            alarm_o <= (state_d == HS_FAILED);
            por_o   <= en && (por_o ||
                       ((state_q == HS_COPING) && (state_d == HS_FAILED) && por_en));
            unique case (state_d)
                HS_NORMAL, HS_WARNING: led_o <= LED_OFF;
                HS_COPING:             led_o <= LED_AMBER;
                HS_FAILED:             led_o <= LED_RED;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/wdt3_supervisor.sv
module wdt3_supervisor
    import wdt3_pkg::*;
#(
    parameter int unsigned      CNT_W      = 16,
    parameter int unsigned      PRE_W      = 17,
    parameter logic [CNT_W-1:0] RELOAD_RST = 16'd1000,
    parameter logic [PRE_W-1:0] PRESC_RST  = 17'd125000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   en_strap,
    input  logic                                   por_en_strap,
    input  logic                                   wr_en,
    input  logic [2:0]                             wr_addr,
    input  logic [((CNT_W > PRE_W) ? CNT_W : PRE_W)-1:0] wr_data,
    output logic [1:0]                             health_o,
    output logic                                   irq_o,
    output logic                                   nmi_o,
    output logic                                   alarm_o,
    output logic                                   por_req_o,
    output logic [1:0]                             led_o
);
    localparam int unsigned LVL = NUM_LEVELS;

    logic [CNT_W-1:0] reload_q [LVL];
    logic [PRE_W-1:0] presc_q;
    logic [LVL-1:0]   active;
    logic [LVL-1:0]   expire;
    logic [LVL-1:0]   reload;
    logic             tick;
    logic             kick_req;
    logic             kick_eff;
    logic             presc_wr;
    health_e          health;
    led_e             led;

    assign kick_req = wr_en && (wr_addr == ADDR_KICK);
    assign presc_wr = wr_en && (wr_addr == ADDR_PRESC);
    assign kick_eff = kick_req && en_strap && (health != HS_FAILED);

    // Reload registers, one per level
    for (genvar g = 0; g < LVL; g++) begin : g_reload_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reload_q[g] <= RELOAD_RST;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                reload_q[g] <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= PRESC_RST;
        end else if (presc_wr) begin
            presc_q <= wr_data[PRE_W-1:0];
        end
    end

    wdt3_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en_strap),
        .restart (kick_eff || presc_wr),
        .divisor (presc_q),
        .tick    (tick)
    );

    // Levels: reload on kick, when idle, or when any higher level expires
    for (genvar g = 0; g < LVL; g++) begin : g_level
        logic higher_exp;
        if (g == LVL - 1) begin : g_top
            assign higher_exp = 1'b0;
        end else begin : g_low
            assign higher_exp = |expire[LVL-1:g+1];
        end
        assign reload[g] = kick_eff || !active[g] || higher_exp;

        wdt3_level #(.CNT_W(CNT_W), .RST_VAL(RELOAD_RST)) u_level (
            .clk        (clk),
            .rst_n      (rst_n),
            .reload_val (reload_q[g]),
            .reload     (reload[g]),
            .active     (active[g]),
            .tick       (tick),
            .expire     (expire[g])
        );
    end

    wdt3_health_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_strap),
        .kick     (kick_eff),
        .por_en   (por_en_strap),
        .expire   (expire),
        .state_o  (health),
        .active_o (active),
        .irq_o    (irq_o),
        .nmi_o    (nmi_o),
        .alarm_o  (alarm_o),
        .por_o    (por_req_o),
        .led_o    (led)
    );

    assign health_o = health;
    assign led_o    = led;

endmodule

// File: rtl/wdt3_checker.sv
module wdt3_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_strap,
    input logic       por_en_strap,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [1:0] health_o,
    input logic       irq_o,
    input logic       nmi_o,
    input logic       alarm_o,
    input logic       por_req_o,
    input logic [1:0] led_o
);
    // R1: warning always carries the maskable interrupt
    a_r1_warning_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (health_o == 2'b01) |-> irq_o);

    // R2: abort pulse lasts one cycle
    a_r2_nmi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    // R3: failed holds while the strap stays high
    a_r3_failed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(health_o) == 2'b11 && $past(en_strap)) |-> (health_o == 2'b11));

    // R4: reset request only when allowed
    a_r4_por_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_req_o) |-> $past(por_en_strap));

    // R6: LED code tracks health
    a_r6_led_code: assert property (@(posedge clk) disable iff (!rst_n)
        (led_o == ((health_o == 2'b11) ? 2'b10 : (health_o == 2'b10) ? 2'b01 : 2'b00)));

    // R7: strap low leaves the block inert
    a_r7_inert: assert property (@(posedge clk) disable iff (!rst_n)
        !en_strap |=> (health_o == 2'b00 && !irq_o && !nmi_o && !alarm_o && !por_req_o));

    // R8: kick in warning or coping returns to normal
    a_r8_kick_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4 && en_strap && (health_o == 2'b01 || health_o == 2'b10))
        |=> (health_o == 2'b00 && !irq_o));

endmodule

bind wdt3_supervisor wdt3_checker u_wdt3_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_strap     (en_strap),
    .por_en_strap (por_en_strap),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .health_o     (health_o),
    .irq_o        (irq_o),
    .nmi_o        (nmi_o),
    .alarm_o      (alarm_o),
    .por_req_o    (por_req_o),
    .led_o        (led_o)
);

// File: tb/wdt3_supervisor_bench.sv
module wdt3_supervisor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_strap = 1'b0;
    logic        por_en_strap = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [16:0] wr_data = '0;
    logic [1:0]  health_o;
    logic        irq_o, nmi_o, alarm_o, por_req_o;
    logic [1:0]  led_o;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int         exp_cyc_q [$];
    logic [7:0] exp_val_q [$];
    string      exp_tag_q [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt3_supervisor u_wdt3_supervisor (
        .clk(clk), .rst_n(rst_n), .en_strap(en_strap), .por_en_strap(por_en_strap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .health_o(health_o), .irq_o(irq_o), .nmi_o(nmi_o), .alarm_o(alarm_o),
        .por_req_o(por_req_o), .led_o(led_o)
    );

    // Expected word: {health, irq, nmi, alarm, por, led}
    task automatic expect_at(input int c, input logic [1:0] h, input logic i,
                             input logic n, input logic a, input logic p,
                             input logic [1:0] l, input string tag);
        exp_cyc_q.push_back(c);
        exp_val_q.push_back({h, i, n, a, p, l});
        exp_tag_q.push_back(tag);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        while (exp_cyc_q.size() != 0 && exp_cyc_q[0] <= cyc) begin
            logic [7:0] act;
            logic [7:0] want;
            string      tag;
            act  = {health_o, irq_o, nmi_o, alarm_o, por_req_o, led_o};
            want = exp_val_q.pop_front();
            tag  = exp_tag_q.pop_front();
            void'(exp_cyc_q.pop_front());
            n_checks++;
            if (act !== want) begin
                n_errors++;
                $display("FAIL %s at edge %0d: actual=%b expected=%b", tag, cyc, act, want);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [16:0] d, output int landed);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        landed = cyc;
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en_strap = 1'b0; por_en_strap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [16:0] p, input logic [16:0] r1,
                         input logic [16:0] r2, input logic [16:0] r3);
        int t;
        wr(3'd3, p, t);
        wr(3'd0, r1, t);
        wr(3'd1, r2, t);
        wr(3'd2, r3, t);
    endtask

    // Enables the strap, then kicks; returns the kick edge
    task automatic arm(output int k);
        @(negedge clk);
        en_strap = 1'b1;
        wr(3'd4, 17'd0, k);
    endtask

    initial begin
        int k;
        int k2;
        int k3;

        do_reset();
        expect_at(cyc + 1, 2'b00, 0, 0, 0, 0, 2'b00, "R1 reset state");

        // R7: strap low, tiny timeouts, kicks -> nothing happens
        setup(17'd1, 17'd1, 17'd1, 17'd1);
        wr(3'd4, 17'd0, k);
        wait_until(k + 20);
        expect_at(cyc + 1, 2'b00, 0, 0, 0, 0, 2'b00, "R7 inert while strap low");

        // Full escalation, reset request disallowed (P=4, R=3,2,2)
        setup(17'd4, 17'd3, 17'd2, 17'd2);
        arm(k);
        expect_at(k + 11, 2'b00, 0, 0, 0, 0, 2'b00, "R5 no expiry before P*R1");
        expect_at(k + 12, 2'b01, 1, 0, 0, 0, 2'b00, "R1 warning with irq");
        expect_at(k + 19, 2'b01, 1, 0, 0, 0, 2'b00, "R5 level2 window");
        expect_at(k + 20, 2'b10, 1, 1, 0, 0, 2'b01, "R2 coping nmi, R6 amber");
        expect_at(k + 21, 2'b10, 1, 0, 0, 0, 2'b01, "R2 nmi one cycle");
        expect_at(k + 28, 2'b11, 1, 0, 1, 0, 2'b10, "R3 failed alarm, R4 gated, R6 red");
        wait_until(k + 30);
        wr(3'd4, 17'd0, k2);
        expect_at(k2 + 5, 2'b11, 1, 0, 1, 0, 2'b10, "R3 kick ignored in failed");
        wait_until(k2 + 6);

        // R4: reset request allowed
        do_reset();
        por_en_strap = 1'b1;
        setup(17'd4, 17'd3, 17'd2, 17'd2);
        arm(k);
        expect_at(k + 12, 2'b01, 1, 0, 0, 0, 2'b00, "R1 warning");
        expect_at(k + 27, 2'b10, 1, 0, 0, 0, 2'b01, "R4 no request before level3");
        expect_at(k + 28, 2'b11, 1, 0, 1, 1, 2'b10, "R4 reset request");
        expect_at(k + 40, 2'b11, 1, 0, 1, 1, 2'b10, "R4 request latched");
        wait_until(k + 41);

        // R8 / R5: kicks in warning and in coping (P=4, R=3,5,5)
        do_reset();
        setup(17'd4, 17'd3, 17'd5, 17'd5);
        arm(k);
        expect_at(k + 12, 2'b01, 1, 0, 0, 0, 2'b00, "R1 warning");
        wait_until(k + 14);
        wr(3'd4, 17'd0, k2);
        expect_at(k2, 2'b00, 0, 0, 0, 0, 2'b00, "R8 kick in warning");
        expect_at(k2 + 11, 2'b00, 0, 0, 0, 0, 2'b00, "R5 full reload after kick");
        expect_at(k2 + 12, 2'b01, 1, 0, 0, 0, 2'b00, "R5 warning again at P*R1");
        expect_at(k2 + 31, 2'b01, 1, 0, 0, 0, 2'b00, "R5 level2 after R2 ticks");
        expect_at(k2 + 32, 2'b10, 1, 1, 0, 0, 2'b01, "R2 coping");
        wait_until(k2 + 34);
        wr(3'd4, 17'd0, k3);
        expect_at(k3, 2'b00, 0, 0, 0, 0, 2'b00, "R8 kick in coping, R6 off");
        expect_at(k3 + 12, 2'b01, 1, 0, 0, 0, 2'b00, "R5 lower levels reloaded");
        wait_until(k3 + 13);

        // R5 boundary: prescaler 0 acts as 1
        do_reset();
        setup(17'd0, 17'd2, 17'd1, 17'd1);
        arm(k);
        expect_at(k + 1, 2'b00, 0, 0, 0, 0, 2'b00, "R5 P=0 first tick");
        expect_at(k + 2, 2'b01, 1, 0, 0, 0, 2'b00, "R5 P=0 warning");
        expect_at(k + 3, 2'b10, 1, 1, 0, 0, 2'b01, "R2 P=0 coping");
        expect_at(k + 4, 2'b11, 1, 0, 1, 0, 2'b10, "R3 P=0 failed");
        wait_until(k + 6);

        // R7: strap dropping clears failed
        @(negedge clk);
        en_strap = 1'b0;
        expect_at(cyc + 1, 2'b00, 0, 0, 0, 0, 2'b00, "R7 strap off clears failed");
        wait_until(cyc + 3);

        // R9: writes accepted while strap is low, used after enabling
        setup(17'd2, 17'd1, 17'd9, 17'd9);
        arm(k);
        expect_at(k + 1, 2'b00, 0, 0, 0, 0, 2'b00, "R9 programmed values before expiry");
        expect_at(k + 2, 2'b01, 1, 0, 0, 0, 2'b00, "R9 programmed values used");
        wait_until(k + 4);

        while (exp_cyc_q.size() != 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule